// File: doc/BRIEF.md
# Prioritized Exception Capture Unit

This unit sits beside the instruction register of a microcoded 8-bit CPU and decides when the processor leaves normal execution to service an exception. Three sources are tracked. The first is a chip-level reset line, which is active low and freezes the core while it is asserted. The second is a non-maskable interrupt line, which is edge-triggered. The third is a maskable interrupt line, which is level-sensitive and gated by the interrupt-disable flag. All request lines are assumed to be synchronous to `clk_i`.

The CPU pulses `ir_load_i` for one cycle whenever it loads the next opcode. At that strobe the unit may enter an exception. When it does, it supplies a substitute opcode that the microcode sequencer uses in place of the fetched one. It also suppresses the program-counter increment, so the return address pushed later is the address of the instruction that was not executed. The exception microcode drives `exc_ack_i` once it has read the vector. The following opcode load then leaves the exception, or chains straight into the next pending one. Releasing the reset line enters the reset exception at once, without waiting for an opcode load.

Top module: `exc_capture`

## Requirements
- R1: While `reset_line_ni` is low, or during the cycle in which it is first seen high again, `cpu_hold_o` is 1, `exc_o` is 0, `pc_inc_inhibit_o` is 0, and `ir_load_i` has no effect.
- R2: At the first clock edge that sees `reset_line_ni` high after a low period, `cpu_hold_o` drops and `exc_o` rises together. At that edge `sub_opcode_o` becomes 8'hFE (code 3'b110) and `vector_addr_o` becomes 16'hFFFC.
- R3: A falling edge on `nmi_ni` is latched as pending, even as a one-cycle pulse between opcode loads. The next load enters with code {INT bit, 0, 1}, where bit 2 is 0 while `int_ni` is low. This gives 8'hF9 or 8'hFD, and the vector is 16'hFFFA.
- R4: Holding `nmi_ni` low after its falling edge produces exactly one NMI entry.
- R5: `int_ni` low is taken at an opcode load only when `irq_disable_i` is 0. It then gives `sub_opcode_o` 8'hFB and vector 16'hFFFE. With `irq_disable_i` 1 it is ignored.
- R6: A pending NMI wins over an enabled INT at the same load.
- R7: `pc_inc_inhibit_o` is 1 exactly in a cycle where `ir_load_i` is 1 and `exc_o` will be 1 after that edge.
- R8: Without an acknowledge, opcode loads keep `exc_o` high and `sub_opcode_o` unchanged. After `exc_ack_i` has been pulsed, the next load clears `exc_o` unless another request is pending.
- R9: An NMI edge that arrives during INT service is entered directly at the load that ends the INT service, with no cycle of `exc_o` low.
- R10: The NMI pending bit is cleared at the first load after an acknowledged NMI service, so that NMI is not entered again.
- R11: The substitute opcode carries the reset, NMI and INT request bits, all active low, in bits 0, 1 and 2. Bits 7..3 are all ones while `exc_o` is 1. `sub_opcode_o` is 8'h00 while `exc_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| reset_line_ni | input | 1 | CPU reset request line, active low |
| nmi_ni | input | 1 | Non-maskable interrupt line, falling-edge triggered |
| int_ni | input | 1 | Maskable interrupt line, active-low level |
| irq_disable_i | input | 1 | Interrupt-disable flag from the status register |
| ir_load_i | input | 1 | One-cycle opcode load strobe |
| exc_ack_i | input | 1 | Acknowledge from exception microcode |
| cpu_hold_o | output | 1 | Core is held in reset |
| exc_o | output | 1 | Exception sequence active |
| sub_opcode_o | output | 8 | Substitute opcode for the sequencer |
| pc_inc_inhibit_o | output | 1 | Suppress PC increment at this load |
| vector_addr_o | output | 16 | Vector table address for the active exception |

## Verification
On every cycle, the assertions check the following properties:
- the core stays quiet while it is held;
- the reset code appears at the release edge;
- `exc_o` changes only at an opcode load or at a reset transition;
- the substitute opcode stays stable between loads;
- the increment inhibit occurs only at a load.

Some behaviours can only be shown by the bench's scenarios:
- which source wins a given load, and the exact code and vector it produces;
- that a held NMI enters only once;
- that an NMI arriving during INT service chains without a gap;
- the sweep over INT level, disable flag and NMI edge, with expected codes computed from the bit layout.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int CODE_W  = 3;
  localparam int RES_BIT = 0;
  localparam int NMI_BIT = 1;
  localparam int INT_BIT = 2;
  typedef logic [CODE_W-1:0] exc_code_t;
  localparam exc_code_t CODE_RESET = 3'b110;
endpackage

// File: rtl/exc_line_sync.sv
module exc_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic reset_line_ni,
  input  logic nmi_ni,
  output logic hold_o,
  output logic reset_rise_o,
  output logic nmi_fall_o
);
  logic res_q, nmi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= 1'b0;
      nmi_q <= 1'b1;
    end else begin
      res_q <= reset_line_ni;
      nmi_q <= nmi_ni;
    end
  end

  assign hold_o       = ~res_q;
  assign reset_rise_o = reset_line_ni & ~res_q;
  assign nmi_fall_o   = nmi_q & ~nmi_ni;

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_rise_o |=> !reset_rise_o && !hold_o); // R2
  AST_FALL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_fall_o |=> !nmi_fall_o); // R4
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic      load_i,
  input  logic      exc_q_i,
  input  logic      acked_i,
  input  exc_code_t code_q_i,
  input  logic      nmi_pend_i,
  input  logic      int_low_i,
  input  logic      irq_disable_i,
  output logic      next_exc_o,
  output logic      fresh_o,
  output exc_code_t code_new_o,
  output logic      nmi_clr_o,
  output logic      inhibit_o
);
  logic stay, nmi_served, nmi_eff, int_take, req;

  always_comb begin
    stay       = exc_q_i & ~acked_i;
    nmi_served = exc_q_i & ~code_q_i[NMI_BIT];
    nmi_eff    = nmi_pend_i & ~nmi_served;
    int_take   = int_low_i & ~irq_disable_i;
    req        = nmi_eff | int_take;
    next_exc_o = stay | req;
    fresh_o    = load_i & ~stay & req;
    nmi_clr_o  = load_i & nmi_served & acked_i;
    inhibit_o  = load_i & next_exc_o;
    code_new_o = '1;
    code_new_o[NMI_BIT] = ~nmi_eff;
    code_new_o[INT_BIT] = ~int_low_i;
  end
endmodule

// File: rtl/exc_vector_map.sv
module exc_vector_map
  import exc_pkg::*;
#(
  parameter int               ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] VEC_RES = 16'hFFFC,
  parameter logic [ADDR_W-1:0] VEC_NMI = 16'hFFFA,
  parameter logic [ADDR_W-1:0] VEC_INT = 16'hFFFE
) (
  input  exc_code_t          code_i,
  output logic [ADDR_W-1:0]  vec_o
);
  always_comb begin
    if (!code_i[RES_BIT])      vec_o = VEC_RES;
    else if (!code_i[NMI_BIT]) vec_o = VEC_NMI;
    else                       vec_o = VEC_INT;
  end
endmodule

// File: rtl/exc_capture.sv
module exc_capture
  import exc_pkg::*;
#(
  parameter int                OPC_W   = 8,
  parameter int                ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] VEC_RES = 16'hFFFC,
  parameter logic [ADDR_W-1:0] VEC_NMI = 16'hFFFA,
  parameter logic [ADDR_W-1:0] VEC_INT = 16'hFFFE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reset_line_ni,
  input  logic              nmi_ni,
  input  logic              int_ni,
  input  logic              irq_disable_i,
  input  logic              ir_load_i,
  input  logic              exc_ack_i,
  output logic              cpu_hold_o,
  output logic              exc_o,
  output logic [OPC_W-1:0]  sub_opcode_o,
  output logic              pc_inc_inhibit_o,
  output logic [ADDR_W-1:0] vector_addr_o
);
  localparam int PAD_W = OPC_W - CODE_W;

  logic      hold, rise, fall, ld_ok, acked;
  logic      exc_q, ackd_q, nmi_pend_q;
  exc_code_t code_q, code_new;
  logic      next_exc, fresh, nmi_clr, inhibit;

  exc_line_sync i_sync (
    .clk_i, .rst_ni, .reset_line_ni, .nmi_ni,
    .hold_o(hold), .reset_rise_o(rise), .nmi_fall_o(fall)
  );

  assign ld_ok = ir_load_i & ~hold & reset_line_ni;
  assign acked = ackd_q | exc_ack_i;

  exc_arbiter i_arb (
    .load_i(ld_ok), .exc_q_i(exc_q), .acked_i(acked), .code_q_i(code_q),
    .nmi_pend_i(nmi_pend_q), .int_low_i(~int_ni), .irq_disable_i,
    .next_exc_o(next_exc), .fresh_o(fresh), .code_new_o(code_new),
    .nmi_clr_o(nmi_clr), .inhibit_o(inhibit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_q      <= 1'b0;
      ackd_q     <= 1'b0;
      nmi_pend_q <= 1'b0;
      code_q     <= '1;
    end else if (!reset_line_ni) begin
      exc_q      <= 1'b0;
      ackd_q     <= 1'b0;
      nmi_pend_q <= 1'b0;
      code_q     <= '1;
    end else if (rise) begin
      exc_q      <= 1'b1;
      ackd_q     <= 1'b0;
      nmi_pend_q <= 1'b0;
      code_q     <= CODE_RESET;
    end else begin
      nmi_pend_q <= (nmi_pend_q & ~nmi_clr) | fall;
      if (ld_ok) begin
        exc_q  <= next_exc;
        ackd_q <= 1'b0;
        if (fresh) code_q <= code_new;
      end else if (exc_ack_i && exc_q) begin
        ackd_q <= 1'b1;
      end
    end
  end

  exc_vector_map #(.ADDR_W(ADDR_W), .VEC_RES(VEC_RES), .VEC_NMI(VEC_NMI),
                   .VEC_INT(VEC_INT)) i_vec (
    .code_i(code_q), .vec_o(vector_addr_o)
  );

  assign cpu_hold_o       = hold;
  assign exc_o            = exc_q;
  assign sub_opcode_o     = exc_q ? {{PAD_W{1'b1}}, code_q} : '0;
  assign pc_inc_inhibit_o = inhibit;

  AST_HOLD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_hold_o |-> !exc_o && !pc_inc_inhibit_o); // R1
  AST_RESET_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cpu_hold_o) |-> exc_o && sub_opcode_o[CODE_W-1:0] == CODE_RESET); // R2
  AST_EXC_RISE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(exc_o) |-> $past(ir_load_i) || $past(cpu_hold_o)); // R3
  AST_EXC_FALL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(exc_o) |-> $past(ir_load_i) || !$past(reset_line_ni)); // R8
  AST_OPC_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o && !ir_load_i && reset_line_ni |=> exc_o && $stable(sub_opcode_o)); // R8
  AST_INHIBIT_AT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_inc_inhibit_o |-> ir_load_i && reset_line_ni); // R7
  AST_INHIBIT_ENTERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_inc_inhibit_o |=> exc_o); // R7
endmodule

// File: tb/test_exc_capture.sv
`timescale 1ns/100ps
module test_exc_capture;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reset_line_n = 1'b0, nmi_n = 1'b1, int_n = 1'b1, dis = 1'b1;
  logic ld = 1'b0, ack = 1'b0;
  logic hold, exc, inh;
  logic [7:0]  opc;
  logic [15:0] vec;
  int checks = 0, errors = 0;
  bit  done = 0;

  always #2.5 clk = ~clk;

  exc_capture i_exc_capture (
    .clk_i(clk), .rst_ni(rst_n), .reset_line_ni(reset_line_n), .nmi_ni(nmi_n),
    .int_ni(int_n), .irq_disable_i(dis), .ir_load_i(ld), .exc_ack_i(ack),
    .cpu_hold_o(hold), .exc_o(exc), .sub_opcode_o(opc),
    .pc_inc_inhibit_o(inh), .vector_addr_o(vec)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  // pulse a load; check the inhibit before the edge
  task automatic load(string req, logic exp_inh);
    ld = 1'b1; #1;
    chk(req, {15'd0, inh}, {15'd0, exp_inh});
    step(); ld = 1'b0;
  endtask

  task automatic ack_pulse();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic nmi_pulse();
    nmi_n = 1'b0; step(); nmi_n = 1'b1; step();
  endtask

  task automatic expect_state(string req, logic e, logic [7:0] o, logic [15:0] v);
    chk(req, {15'd0, exc}, {15'd0, e});
    chk(req, {8'd0, opc}, {8'd0, o});
    if (e) chk(req, vec, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    step();
    // R1: held state, loads ignored
    chk("R1 hold", {15'd0, hold}, 16'd1);
    expect_state("R1 idle", 1'b0, 8'h00, 16'h0);
    load("R1 inhibit while held", 1'b0);
    chk("R1 exc while held", {15'd0, exc}, 16'd0);
    // R2: release
    reset_line_n = 1'b1; #1;
    chk("R1 release cycle hold", {15'd0, hold}, 16'd1);
    step();
    chk("R2 hold drop", {15'd0, hold}, 16'd0);
    expect_state("R2 reset entry", 1'b1, 8'hFE, 16'hFFFC);
    // R8: no ack keeps exception
    load("R7 inhibit stay", 1'b1);
    expect_state("R8 persist", 1'b1, 8'hFE, 16'hFFFC);
    ack_pulse();
    load("R7 no inhibit on exit", 1'b0);
    expect_state("R8 R11 exit", 1'b0, 8'h00, 16'h0);
    load("R7 idle load", 1'b0);
    // R5: INT masked then enabled
    int_n = 1'b0;
    load("R5 masked", 1'b0);
    chk("R5 masked exc", {15'd0, exc}, 16'd0);
    dis = 1'b0;
    load("R5 enabled inhibit", 1'b1);
    expect_state("R5 int entry", 1'b1, 8'hFB, 16'hFFFE);
    // R9: NMI during INT service chains
    nmi_pulse();
    ack_pulse();
    load("R9 chain inhibit", 1'b1);
    expect_state("R9 R3 nmi chained", 1'b1, 8'hF9, 16'hFFFA);
    // R10: served NMI not re-entered
    ack_pulse(); dis = 1'b1;
    load("R10 exit", 1'b0);
    expect_state("R10 no reentry", 1'b0, 8'h00, 16'h0);
    int_n = 1'b1;
    load("R10 idle", 1'b0);
    // R4: NMI held low
    nmi_n = 1'b0; step();
    load("R3 nmi inhibit", 1'b1);
    expect_state("R3 nmi int high", 1'b1, 8'hFD, 16'hFFFA);
    ack_pulse();
    load("R4 exit", 1'b0);
    load("R4 held low no second entry", 1'b0);
    chk("R4 exc", {15'd0, exc}, 16'd0);
    nmi_n = 1'b1; step();
    // R6: NMI over INT
    int_n = 1'b0; dis = 1'b0;
    nmi_pulse();
    load("R6 inhibit", 1'b1);
    expect_state("R6 nmi wins", 1'b1, 8'hF9, 16'hFFFA);
    ack_pulse(); dis = 1'b1; int_n = 1'b1;
    load("R6 exit", 1'b0);
    // sweep INT level x disable x NMI edge
    for (int k = 0; k < 8; k++) begin
      logic il, d, n, e;
      logic [2:0] code;
      il = k[0]; d = k[1]; n = k[2];
      int_n = ~il; dis = d;
      if (n) nmi_pulse(); else step();
      e = n | (il & ~d);
      code = n ? {~il, 1'b0, 1'b1} : 3'b011;
      load("R7 sweep inhibit", e);
      expect_state("R11 sweep", e, e ? {5'h1F, code} : 8'h00,
                   n ? 16'hFFFA : 16'hFFFE);
      int_n = 1'b1; dis = 1'b1;
      ack_pulse();
      load("R8 sweep exit", 1'b0);
      chk("R8 sweep cleared", {15'd0, exc}, 16'd0);
    end
    // R1: reset during an exception
    int_n = 1'b0; dis = 1'b0;
    load("R5 pre reset", 1'b1);
    reset_line_n = 1'b0; step();
    chk("R1 reset aborts", {15'd0, exc}, 16'd0);
    chk("R1 hold again", {15'd0, hold}, 16'd1);
    load("R1 load ignored", 1'b0);
    reset_line_n = 1'b1; step();
    expect_state("R2 second release", 1'b1, 8'hFE, 16'hFFFC);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule